// File: doc/BRIEF.md
# Snoop Result Memory Response Controller

This block sits on the memory side of a snooping shared bus and settles, for one read transaction at a time, who supplies the requested block. Memory starts its fetch the moment a read request is seen, without waiting for snoop results. While the fetch is under way the controller watches the wired-OR snoop lines and the response bus. A cache holding a modified copy can claim the transaction by raising the dirty line or by placing its own data response on the bus. The inhibit line lets slow snoopers hold memory back until their lookup finishes.

Each transaction ends with exactly one single-cycle outcome pulse. Memory may drive its own response. It may abort its response because a cache answers a read-exclusive request. It may take the cache's data in as a writeback because a cache answers a plain read. The memory array, its access latency and bus arbitration stay outside the block. Memory readiness arrives as an input pulse or level. A plain read and a read-exclusive are told apart by a qualifier sampled with the start pulse.

Top module: `snoop_mem_resp_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_drive`, `mem_abort` and `wb_accept` are all low, and the controller is idle.
- R2: In an active transaction, suppose `mem_ready` is high (or was seen earlier) while `snp_inhibit`, `snp_dirty` and `cache_resp` are low. Then `mem_drive` pulses high for exactly one cycle, in the cycle after that sampling edge.
- R3: A `mem_ready` seen while `snp_inhibit` is high is remembered, and no response is driven. `mem_drive` follows in the cycle after the first edge at which inhibit is sampled low.
- R4: Once `snp_dirty` is sampled high during an active transaction, `mem_drive` does not pulse for the rest of that transaction. This holds whether or not memory is ready and whatever inhibit does.
- R5: For a plain read (`req_excl` low at start), a `cache_resp` sampled during the transaction ends it with a one-cycle `wb_accept` pulse in the following cycle.
- R6: For a read-exclusive (`req_excl` high at start), a `cache_resp` ends the transaction with a one-cycle `mem_abort` pulse, and `wb_accept` stays low.
- R7: A cache response seen before memory is ready ends the transaction. A later `mem_ready` produces no output.
- R8: `snp_shared` has no effect on which outcome is chosen or when it occurs.
- R9: At most one of the three outcome outputs is high in any cycle. Each transaction ends with exactly one pulse.
- R10: While idle, `mem_ready`, `cache_resp` and the snoop lines are ignored, and all three outputs stay low.
- R11: If `cache_resp` and `mem_ready` are sampled in the same cycle with inhibit low, the cache response wins and `mem_drive` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | A read request has appeared on the bus; starts a transaction when idle |
| req_excl | input | 1 | Qualifier sampled with `req_start`: 1 for read-exclusive, 0 for plain read |
| mem_ready | input | 1 | Memory fetch data is available |
| snp_shared | input | 1 | Wired-OR: some cache holds a copy |
| snp_dirty | input | 1 | Wired-OR: some cache holds a modified copy |
| snp_inhibit | input | 1 | Wired-OR: a snoop is still in progress; memory must wait |
| cache_resp | input | 1 | A cache's data response for this transaction is on the response bus |
| mem_drive | output | 1 | One-cycle pulse: memory drives its response |
| mem_abort | output | 1 | One-cycle pulse: memory drops its response without storing the cache data |
| wb_accept | output | 1 | One-cycle pulse: memory drops its response and absorbs the cache data as a writeback |

## Verification
A wrong internal state shows at the outcome pins within one cycle of the deciding sample. A lost ready flag leaves the transaction hanging after inhibit is released, so no pulse appears where `mem_drive` is expected. A lost dirty mark turns into a stray `mem_drive` on the next ready cycle. A wrong exclusive qualifier swaps `wb_accept` and `mem_abort`. A controller that fails to go back to idle shows up as an output pulse caused by stimulus applied between transactions.

// File: rtl/srmc_pkg.sv
package srmc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FETCH  = 2'd1,
        PH_CLAIM  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        END_NONE  = 2'd0,
        END_DRIVE = 2'd1,
        END_ABORT = 2'd2,
        END_WB    = 2'd3
    } ending_e;

    typedef struct packed {
        phase_e  phase;
        logic    excl;
        ending_e ending;
    } ctl_t;

endpackage

// File: rtl/srmc_ready_track.sv
module srmc_ready_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic set,
    output logic ready_q
);
    logic ready_d;

    always_comb begin
        ready_d = ready_q;
        if (set)
            ready_d = 1'b1;
        if (clear)
            ready_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= 1'b0;
        else
            ready_q <= ready_d;
    end

endmodule

// File: rtl/srmc_fsm.sv
module srmc_fsm
    import srmc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_start,
    input  logic    req_excl,
    input  logic    ready_now,
    input  logic    snp_dirty,
    input  logic    snp_inhibit,
    input  logic    cache_resp,
    output logic    busy,
    output logic    start_take,
    output logic    excl,
    output ending_e ending
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.ending = END_NONE;
        start_take   = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (req_start) begin
                    start_take  = 1'b1;
                    ctl_d.phase = PH_FETCH;
                    ctl_d.excl  = req_excl;
                end
            end
            PH_FETCH: begin
                if (cache_resp) begin
                    ctl_d.phase  = PH_IDLE;
                    ctl_d.ending = ctl_q.excl ? END_ABORT : END_WB;
                end else if (snp_dirty) begin
                    ctl_d.phase = PH_CLAIM;
                end else if (ready_now && !snp_inhibit) begin
                    ctl_d.phase  = PH_IDLE;
                    ctl_d.ending = END_DRIVE;
                end
            end
            PH_CLAIM: begin
                if (cache_resp) begin
                    ctl_d.phase  = PH_IDLE;
                    ctl_d.ending = ctl_q.excl ? END_ABORT : END_WB;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.phase  <= PH_IDLE;
            ctl_q.excl   <= 1'b0;
            ctl_q.ending <= END_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy   = (ctl_q.phase != PH_IDLE);
    assign excl   = ctl_q.excl;
    assign ending = ctl_q.ending;

    // R10
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_IDLE && req_start) |=> (ctl_q.phase == PH_FETCH));

    // R4
    claim_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_CLAIM) |=> (ctl_q.ending != END_DRIVE));

endmodule

// File: rtl/srmc_out_dec.sv
module srmc_out_dec
    import srmc_pkg::*;
(
    input  ending_e ending,
    output logic    drive,
    output logic    abort,
    output logic    wb
);
    always_comb begin
        drive = 1'b0;
        abort = 1'b0;
        wb    = 1'b0;
        unique case (ending)
            END_DRIVE: drive = 1'b1;
            END_ABORT: abort = 1'b1;
            END_WB:    wb    = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/snoop_mem_resp_ctrl.sv
module snoop_mem_resp_ctrl
    import srmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_start,
    input  logic req_excl,
    input  logic mem_ready,
    input  logic snp_shared,
    input  logic snp_dirty,
    input  logic snp_inhibit,
    input  logic cache_resp,
    output logic mem_drive,
    output logic mem_abort,
    output logic wb_accept
);
    logic    busy;
    logic    start_take;
    logic    excl;
    logic    ready_q;
    logic    ready_now;
    logic    shared_unused;
    ending_e ending;

    assign shared_unused = snp_shared;
    assign ready_now     = ready_q | mem_ready;

    srmc_ready_track i_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_take),
        .set     (busy & mem_ready),
        .ready_q (ready_q)
    );

    srmc_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_start   (req_start),
        .req_excl    (req_excl),
        .ready_now   (ready_now),
        .snp_dirty   (snp_dirty),
        .snp_inhibit (snp_inhibit),
        .cache_resp  (cache_resp),
        .busy        (busy),
        .start_take  (start_take),
        .excl        (excl),
        .ending      (ending)
    );

    srmc_out_dec i_dec (
        .ending (ending),
        .drive  (mem_drive),
        .abort  (mem_abort),
        .wb     (wb_accept)
    );

    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_drive, mem_abort, wb_accept}));

    // R9
    outcome_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_drive | mem_abort | wb_accept) |-> ($past(busy) && !busy));

    // R3
    drive_not_inhibited_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_drive |-> !$past(snp_inhibit));

    // R4
    drive_not_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_drive |-> !$past(snp_dirty));

    // R6
    excl_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_accept |-> !excl);

    // R5
    resp_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cache_resp) |=> (mem_abort || wb_accept));

endmodule

// File: tb/test_snoop_mem_resp_ctrl.sv
module test_snoop_mem_resp_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    logic clk = 1'b0;
    logic rst_n;
    logic req_start, req_excl, mem_ready;
    logic snp_shared, snp_dirty, snp_inhibit, cache_resp;
    logic mem_drive, mem_abort, wb_accept;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_mem_resp_ctrl i_snoop_mem_resp_ctrl (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_excl(req_excl),
        .mem_ready(mem_ready), .snp_shared(snp_shared), .snp_dirty(snp_dirty),
        .snp_inhibit(snp_inhibit), .cache_resp(cache_resp),
        .mem_drive(mem_drive), .mem_abort(mem_abort), .wb_accept(wb_accept)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input logic d, input logic a, input logic w, input string req);
        n_checks++;
        if ({mem_drive, mem_abort, wb_accept} !== {d, a, w}) begin
            n_fail++;
            $display("FAIL %s: drive/abort/wb actual=%b%b%b expected=%b%b%b",
                     req, mem_drive, mem_abort, wb_accept, d, a, w);
        end
    endtask

    task automatic clear_in();
        req_start = 0; req_excl = 0; mem_ready = 0; snp_shared = 0;
        snp_dirty = 0; snp_inhibit = 0; cache_resp = 0;
    endtask

    task automatic begin_txn(input logic ex);
        req_start = 1; req_excl = ex;
        cyc();
        req_start = 0; req_excl = 0;
    endtask

    task automatic t_reset();
        clear_in();
        rst_n = 0;
        cyc();
        expect_out(0, 0, 0, "R1 in reset");
        cyc();
        rst_n = 1;
        cyc();
        expect_out(0, 0, 0, "R1 after reset");
    endtask

    task automatic t_clean_read();
        begin_txn(0);
        expect_out(0, 0, 0, "R2 waiting");
        cyc(); cyc();
        expect_out(0, 0, 0, "R2 still waiting");
        mem_ready = 1;
        cyc();
        mem_ready = 0;
        expect_out(1, 0, 0, "R2 drive");
        cyc();
        expect_out(0, 0, 0, "R9 single pulse");
    endtask

    task automatic t_inhibit_hold();
        begin_txn(0);
        snp_inhibit = 1; mem_ready = 1;
        cyc();
        mem_ready = 0;
        expect_out(0, 0, 0, "R3 held by inhibit");
        cyc();
        expect_out(0, 0, 0, "R3 held, ready remembered");
        snp_inhibit = 0;
        cyc();
        expect_out(1, 0, 0, "R3 drive after release");
        cyc();
        expect_out(0, 0, 0, "R9 pulse ends");
    endtask

    task automatic t_dirty_read();
        begin_txn(0);
        snp_inhibit = 1; mem_ready = 1;
        cyc();
        mem_ready = 0;
        cyc();
        snp_inhibit = 0; snp_dirty = 1;
        cyc();
        expect_out(0, 0, 0, "R4 dirty cancels");
        snp_dirty = 0;
        cyc(); cyc();
        expect_out(0, 0, 0, "R4 no drive after dirty");
        cache_resp = 1;
        cyc();
        cache_resp = 0;
        expect_out(0, 0, 1, "R5 writeback accepted");
        cyc();
        expect_out(0, 0, 0, "R9 one ending");
    endtask

    task automatic t_early_resp();
        begin_txn(0);
        cache_resp = 1;
        cyc();
        cache_resp = 0;
        expect_out(0, 0, 1, "R7 early cache response");
        mem_ready = 1;
        cyc();
        mem_ready = 0;
        expect_out(0, 0, 0, "R7 late ready ignored");
    endtask

    task automatic t_excl_resp();
        begin_txn(1);
        cache_resp = 1;
        cyc();
        cache_resp = 0;
        expect_out(0, 1, 0, "R6 exclusive abort");
    endtask

    task automatic t_excl_dirty();
        begin_txn(1);
        snp_dirty = 1; mem_ready = 1;
        cyc();
        snp_dirty = 0; mem_ready = 0;
        expect_out(0, 0, 0, "R4 exclusive dirty cancels");
        cyc();
        expect_out(0, 0, 0, "R4 exclusive waiting for cache");
        cache_resp = 1;
        cyc();
        cache_resp = 0;
        expect_out(0, 1, 0, "R6 exclusive abort after dirty");
    endtask

    task automatic t_shared();
        begin_txn(0);
        snp_shared = 1;
        cyc();
        expect_out(0, 0, 0, "R8 shared alone no outcome");
        mem_ready = 1;
        cyc();
        mem_ready = 0; snp_shared = 0;
        expect_out(1, 0, 0, "R8 shared still drives");
    endtask

    task automatic t_same_cycle();
        begin_txn(0);
        mem_ready = 1; cache_resp = 1;
        cyc();
        mem_ready = 0; cache_resp = 0;
        expect_out(0, 0, 1, "R11 cache wins over ready");
    endtask

    task automatic t_idle_ignore();
        mem_ready = 1; cache_resp = 1; snp_dirty = 1; snp_inhibit = 1; snp_shared = 1;
        for (int i = 0; i < 3; i++) begin
            cyc();
            expect_out(0, 0, 0, "R10 idle ignores inputs");
        end
        clear_in();
        begin_txn(0);
        mem_ready = 1;
        cyc();
        mem_ready = 0;
        expect_out(1, 0, 0, "R10 fresh start after idle");
    endtask

    initial begin
        t_reset();
        t_clean_read();
        t_inhibit_hold();
        t_dirty_read();
        t_early_resp();
        t_excl_resp();
        t_excl_dirty();
        t_shared();
        t_same_cycle();
        t_idle_ignore();
        cyc();
        done = 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG_CYCLES && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            done = 1'b1;
        end
    end

    initial begin
        wait (done);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule